// File: doc/BRIEF.md
# Blanking-Window Frame Buffer Arbiter

This block shares one single-port pixel memory between two users: the display scan-out and a client that writes pixels. A sync generator outside the block supplies a display-enable flag and the current column and row. While display enable is high, the block turns that position into a linear memory address and issues a read on every pixel clock. The memory answers one cycle later, and the returned pixel goes straight to the three colour outputs.

The write client raises a request and holds an address and a data value. The block grants the request only when the display is blanked, so scan-out reads always win and are never delayed. A grant lasts one cycle and commits the write in that same cycle. A request whose address lies past the end of the visible raster is still granted, so the client is released, but the memory is left unchanged. The colour outputs are black whenever the display enable of the previous cycle was low.

A pixel is three one-bit colour components, so each component is either full on or off. The default raster is 640 columns by 480 rows, scanned left to right and then top to bottom.

Top module: `fb_blank_arbiter`

## Requirements
- R1: While `disp_en` is high, `mem_addr` equals `pos_y * H_ACT + pos_x` in the same cycle, and `mem_we` is low.
- R2: In a cycle after one where `disp_en` was high, `rgb` equals `mem_rdata`, so the pixel at each position appears one cycle after its coordinates. The bit order is `rgb[2]` red, `rgb[1]` green, `rgb[0]` blue.
- R3: `wr_gnt` is never high while `disp_en` is high. A request made during active video stays pending until blanking.
- R4: `wr_gnt` is never high for two cycles in a row. A request that is held continuously is granted at most every other cycle.
- R5: In a cycle where `wr_gnt` is high and `wr_addr < H_ACT*V_ACT`, `mem_we` is high, `mem_addr` equals `wr_addr` and `mem_wdata` equals `wr_data`. `mem_we` is never high without `wr_gnt`.
- R6: In a cycle after one where `disp_en` was low, `rgb` is 3'b000.
- R7: A request with `wr_addr >= H_ACT*V_ACT` is granted like any other, but `mem_we` stays low, so memory is unchanged.
- R8: A request that is high during blanking is granted in that same cycle, unless a grant was given in the previous cycle.
- R9: While `rst_n` is low, `wr_gnt`, `mem_we` and `rgb` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | High during the visible part of the scan |
| pos_x | input | X_W | Current column from the timing generator |
| pos_y | input | Y_W | Current row from the timing generator |
| mem_addr | output | ADDR_W | Memory address (scan read or client write) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 3 | Pixel to store |
| mem_rdata | input | 3 | Pixel read back, one cycle after its address |
| wr_req | input | 1 | Client write request, held until granted |
| wr_addr | input | ADDR_W | Client linear pixel address |
| wr_data | input | 3 | Client pixel value |
| wr_gnt | output | 1 | One-cycle grant; the write occurs in this cycle |
| rgb | output | 3 | Colour output {red, green, blue} |

## Verification
The read address, the grant and the write strobe all respond in the same cycle as the inputs that cause them. A pixel reaches `rgb` exactly one cycle after its coordinates, because of the synchronous read of the memory model in the bench. The bench changes its inputs just after each rising edge and compares on the falling edge. The reference model keeps the previous cycle's enable, address and grant, so it can give the one-cycle-late colour and the back-to-back grant rule at the cycle where each is due. Because the shadow frame is updated only for in-range granted writes, later frames show any write the design made or dropped by mistake.

// File: rtl/fb_arb_pkg.sv
`timescale 1ns/1ps
package fb_arb_pkg;

  localparam int unsigned PIX_BITS = 3;

  typedef struct packed {
    logic red;
    logic green;
    logic blue;
  } pixel_t;

  // linear index of a raster position, row-major
  function automatic logic [31:0] raster_index(input logic [31:0] col,
                                               input logic [31:0] row,
                                               input logic [31:0] width);
    return row * width + col;
  endfunction

  // true when a linear index names a visible pixel
  function automatic logic index_visible(input logic [31:0] idx,
                                         input logic [31:0] depth);
    return idx < depth;
  endfunction

endpackage

// File: rtl/fb_scan_fetch.sv
`timescale 1ns/1ps
module fb_scan_fetch #(
  parameter int H_ACT  = 640,
  parameter int X_W    = 10,
  parameter int Y_W    = 9,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic [X_W-1:0]    pos_x,
  input  logic [Y_W-1:0]    pos_y,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              show_q
);
  import fb_arb_pkg::*;

  logic [31:0] idx_full;

  assign idx_full  = raster_index(32'(pos_x), 32'(pos_y), 32'(H_ACT));
  assign scan_addr = idx_full[ADDR_W-1:0];

  // marks that the data returning next cycle belongs to a visible pixel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) show_q <= 1'b0;
    else        show_q <= disp_en;
  end
endmodule

// File: rtl/fb_write_gate.sv
`timescale 1ns/1ps
module fb_write_gate #(
  parameter int ADDR_W = 19,
  parameter int DEPTH  = 307200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_gnt,
  output logic              wr_commit
);
  import fb_arb_pkg::*;

  logic gnt_q;
  logic addr_ok;

  // full address space is visible: no range compare needed
  generate
    if (DEPTH == (1 << ADDR_W)) begin : g_full
      assign addr_ok = 1'b1;
    end else begin : g_ranged
      assign addr_ok = index_visible(32'(wr_addr), 32'(DEPTH));
    end
  endgenerate

  assign wr_gnt    = rst_n & wr_req & ~disp_en & ~gnt_q;
  assign wr_commit = wr_gnt & addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= wr_gnt;
  end
endmodule

// File: rtl/fb_pixel_out.sv
`timescale 1ns/1ps
module fb_pixel_out (
  input  logic                        show_q,
  input  fb_arb_pkg::pixel_t          rd_pix,
  output fb_arb_pkg::pixel_t          out_pix
);
  always_comb begin
    out_pix = '0;
    if (show_q) out_pix = rd_pix;
  end
endmodule

// File: rtl/fb_blank_arbiter.sv
`timescale 1ns/1ps
module fb_blank_arbiter #(
  parameter int H_ACT  = 640,
  parameter int V_ACT  = 480,
  parameter int X_W    = $clog2(H_ACT),
  parameter int Y_W    = $clog2(V_ACT),
  parameter int DEPTH  = H_ACT * V_ACT,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic [X_W-1:0]    pos_x,
  input  logic [Y_W-1:0]    pos_y,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [2:0]        mem_wdata,
  input  logic [2:0]        mem_rdata,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [2:0]        wr_data,
  output logic              wr_gnt,
  output logic [2:0]        rgb
);
  import fb_arb_pkg::*;

  // named internal events, observed by the bound checker
  logic [ADDR_W-1:0] scan_addr;
  logic              show_q;
  logic              write_commit;
  pixel_t            rd_pix;
  pixel_t            out_pix;

  fb_scan_fetch #(
    .H_ACT(H_ACT), .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en),
    .pos_x(pos_x), .pos_y(pos_y),
    .scan_addr(scan_addr), .show_q(show_q)
  );

  fb_write_gate #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en),
    .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_gnt(wr_gnt), .wr_commit(write_commit)
  );

  assign rd_pix = pixel_t'(mem_rdata);

  fb_pixel_out u_out (
    .show_q(show_q), .rd_pix(rd_pix), .out_pix(out_pix)
  );

  // scan-out owns the port during active video
  assign mem_addr  = disp_en ? scan_addr : wr_addr;
  assign mem_we    = write_commit;
  assign mem_wdata = wr_data;
  assign rgb       = out_pix;
endmodule

// File: rtl/fb_blank_arbiter_chk.sv
`timescale 1ns/1ps
module fb_blank_arbiter_chk #(
  parameter int H_ACT  = 640,
  parameter int X_W    = 10,
  parameter int Y_W    = 9,
  parameter int DEPTH  = 307200,
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_en,
  input logic [X_W-1:0]    pos_x,
  input logic [Y_W-1:0]    pos_y,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [2:0]        mem_rdata,
  input logic              wr_gnt,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [2:0]        rgb
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_scan_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (int'(mem_addr) == int'(pos_y) * H_ACT + int'(pos_x)) && !mem_we);

  p_pixel_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(disp_en)) |-> rgb == mem_rdata);

  p_no_grant_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> !wr_gnt);

  p_grant_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gnt |=> !wr_gnt);

  p_write_needs_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_gnt && mem_addr == wr_addr);

  p_blank_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(disp_en)) |-> rgb == 3'b000);

  p_outside_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gnt && int'(wr_addr) >= DEPTH) |-> !mem_we);

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r9: assert (!wr_gnt && !mem_we);
    end
  end
endmodule

bind fb_blank_arbiter fb_blank_arbiter_chk #(
  .H_ACT(H_ACT), .X_W(X_W), .Y_W(Y_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .pos_x(pos_x), .pos_y(pos_y),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_rdata(mem_rdata),
  .wr_gnt(wr_gnt), .wr_addr(wr_addr), .rgb(rgb)
);

// File: tb/fb_blank_arbiter_tb.sv
`timescale 1ns/1ps
module fb_blank_arbiter_tb;
  localparam int H = 12, V = 6, HT = 16, VT = 8;
  localparam int XW = 4, YW = 3, AW = 7, NPIX = H * V;

  logic clk = 0, rst_n = 0;
  logic disp_en = 0;
  logic [XW-1:0] pos_x = '0;
  logic [YW-1:0] pos_y = '0;
  logic [AW-1:0] mem_addr, wr_addr = '0;
  logic mem_we, wr_gnt, wr_req = 0;
  logic [2:0] mem_wdata, mem_rdata = '0, wr_data = '0, rgb;

  fb_blank_arbiter #(.H_ACT(H), .V_ACT(V)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .pos_x(pos_x), .pos_y(pos_y),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_gnt(wr_gnt), .rgb(rgb));

  always #10 clk = ~clk;

  // single-port memory with one-cycle synchronous read
  logic [2:0] mem [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0, ended = 0, client_done = 0;
  int shadow [0:(1<<AW)-1];
  bit r_gnt = 0, r_de = 0;
  int r_idx = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural reference, compared every falling edge
  always @(negedge clk) begin
    if (!done) begin
      bit eg, ew;
      int e_rgb;
      string t;
      eg = rst_n && wr_req && !disp_en && !r_gnt;
      ew = eg && (int'(wr_addr) < NPIX);
      if (!rst_n) t = "R9"; else if (disp_en) t = "R3"; else if (r_gnt) t = "R4"; else t = "R8";
      chk(wr_gnt === eg, t, int'(wr_gnt), int'(eg));
      t = (!rst_n) ? "R9" : ((int'(wr_addr) >= NPIX) ? "R7" : "R5");
      chk(mem_we === ew, t, int'(mem_we), int'(ew));
      if (rst_n && disp_en)
        chk(int'(mem_addr) == int'(pos_y) * H + int'(pos_x), "R1", int'(mem_addr),
            int'(pos_y) * H + int'(pos_x));
      if (ew) begin
        chk(mem_addr == wr_addr, "R5", int'(mem_addr), int'(wr_addr));
        chk(mem_wdata == wr_data, "R5", int'(mem_wdata), int'(wr_data));
      end
      e_rgb = r_de ? shadow[r_idx] : 0;
      t = (!rst_n) ? "R9" : (r_de ? "R2" : "R6");
      chk(int'(rgb) == e_rgb, t, int'(rgb), e_rgb);
      r_gnt = eg;
      r_de  = rst_n && disp_en;
      r_idx = int'(pos_y) * H + int'(pos_x);
      if (ew) shadow[int'(wr_addr)] = int'(wr_data);
    end
  end

  // scan timing and reset
  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      mem[i] = 3'((i * 5 + 3) & 7);
      shadow[i] = (i * 5 + 3) & 7;
    end
    wr_req = 1;                       // R9: request during reset must not be granted
    repeat (4) @(posedge clk);
    #1 rst_n = 1; wr_req = 0;
    while (!client_done) begin
      for (int vy = 0; vy < VT; vy++)
        for (int hx = 0; hx < HT; hx++) begin
          @(posedge clk); #1;
          pos_x = XW'(hx); pos_y = YW'(vy);
          disp_en = (hx < H) && (vy < V);
        end
    end
    for (int f = 0; f < 2; f++)
      for (int vy = 0; vy < VT; vy++)
        for (int hx = 0; hx < HT; hx++) begin
          @(posedge clk); #1;
          pos_x = XW'(hx); pos_y = YW'(vy);
          disp_en = (hx < H) && (vy < V);
        end
    @(negedge clk);
    done = 1;
    finish_run();
  end

  // write client: held requests, back-to-back and out-of-range addresses
  initial begin
    void'($urandom(17));
    @(posedge rst_n);
    for (int n = 0; n < 200; n++) begin
      int wait_c;
      repeat ($urandom % 12) @(posedge clk);
      #1;
      wr_req = 1;
      wr_addr = AW'($urandom % (1<<AW));
      wr_data = 3'($urandom % 8);
      for (int k = 0; k < 3; k++) begin
        wait_c = 0;
        do begin
          @(negedge clk);
          wait_c++;
        end while (!wr_gnt && wait_c < 500);
        if (!wr_gnt) chk(0, "R8", 0, 1);
        @(posedge clk); #1;
        if (n % 4 != 0) break;
        wr_addr = AW'($urandom % (1<<AW));   // keep request high for another write
        wr_data = 3'($urandom % 8);
      end
      wr_req = 0;
    end
    client_done = 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    done = 1;
    finish_run();
  end
endmodule